// File: doc/BRIEF.md
# Write-Conflict Stall Unit for a Pipelined Bucket Table

This unit sits in a pipelined hash table, after the stage that turns a key into a bucket address and before the stage that reads that bucket from memory. Several requests can be in the pipeline at once. A later request must not read a bucket that an earlier insert or delete has yet to write back. To prevent this, the unit keeps an ordered list of bucket addresses, one for each write-type request it has let through whose write has not yet finished. Each incoming address is compared against every listed address in the same cycle. On any match, the request is held at the input.

A request passes through in the cycle it arrives, with no change, unless it is stalled. The write stage pulses a release strobe each time it finishes a write. Writes finish in the order they were issued, so each strobe removes the oldest listed address. The list depth is a parameter; it should cover the number of writes that the memory latency can keep in flight at once, and the default is 64.

Top module: `raw_guard`

## Requirements
- R1: Operation codes are 2'b01 (insert) and 2'b10 (delete), the write types, plus 2'b00 and 2'b11, the read types. An accepted write-type request (in_valid, in_ready both high at a clock edge) records its bucket address and raises occupancy by one at that edge.
- R2: A read-type request never records an address. It passes when its address matches no recorded entry.
- R3: A request of any type whose address equals a recorded address is stalled: in_ready and out_valid are both low.
- R4: A release strobe and an accepted write in the same cycle both take effect. Occupancy stays the same, the oldest entry is removed and the new address is recorded.
- R5: A request that matches only the entry released in the current cycle is still stalled in that cycle. It is accepted in the next cycle.
- R6: When occupancy equals the depth, write-type requests are stalled whatever their address. Read-type requests with no match still pass.
- R7: Entries are released oldest first. A younger matching entry keeps stalling after an older one is released.
- R8: A release strobe while occupancy is zero is ignored, and occupancy stays zero.
- R9: While out_ready is low, in_ready is low and nothing is recorded.
- R10: After reset, occupancy is zero and no request is stalled.
- R11: A request that is not stalled appears on the output in the same cycle, with its operation code and address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming request valid |
| in_ready | output | 1 | Incoming request accepted |
| in_op | input | 2 | Operation code |
| in_addr | input | ADDR_W | Bucket address |
| out_valid | output | 1 | Outgoing request valid |
| out_ready | input | 1 | Downstream read stage ready |
| out_op | output | 2 | Forwarded operation code |
| out_addr | output | ADDR_W | Forwarded bucket address |
| wr_done | input | 1 | Write stage finished its oldest write |
| occupancy | output | $clog2(DEPTH+1) | Number of recorded addresses |

## Verification
A wrong head or tail pointer, or a valid flag that is cleared or set in error, shows at the ports in one of two ways. A request that should be held passes through, or a request that should pass is held. Either shows in the first cycle in which a request targets the affected address, so the bench probes the addresses just recorded or released right after each push and each release. A wrong occupancy count shows at once on the occupancy output, and it also shows when the list becomes full, because write-type requests then stall one entry early or one entry late.

// File: rtl/raw_guard.sv
module raw_guard #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [1:0]                 in_op,
  input  logic [ADDR_W-1:0]          in_addr,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [1:0]                 out_op,
  output logic [ADDR_W-1:0]          out_addr,
  input  logic                       wr_done,
  output logic [$clog2(DEPTH+1)-1:0] occupancy
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [ADDR_W-1:0] slot [DEPTH];
  logic [DEPTH-1:0]  live, match;
  logic [PW-1:0]     head, tail;
  logic [CW-1:0]     count;
  logic              is_wr, hit, full, block, push, pop;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = live[i] && (slot[i] == in_addr);
  end

  assign hit       = |match;
  assign is_wr     = (in_op == 2'b01) || (in_op == 2'b10);
  assign full      = (count == FULL);
  assign block     = hit || (is_wr && full);
  assign out_valid = in_valid && !block;
  assign in_ready  = out_ready && !block;
  assign out_op    = in_op;
  assign out_addr  = in_addr;
  assign push      = in_valid && in_ready && is_wr;
  assign pop       = wr_done && (count != '0);
  assign occupancy = count;

  always_ff @(posedge clk) begin
    if (push) slot[tail] <= in_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (pop) begin
        live[head] <= 1'b0;
        head <= (head == LAST) ? '0 : head + 1'b1;
      end
      if (push) begin
        live[tail] <= 1'b1;
        tail <= (tail == LAST) ? '0 : tail + 1'b1;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1)); // R1
  AST_READ_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !is_wr && !wr_done) |=> $stable(count)); // R2
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL); // R6
  AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && count == '0 && !push) |=> (count == '0)); // R8
  AST_HOLD_ON_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !wr_done) |=> $stable(count)); // R9
endmodule

// File: tb/test_raw_guard.sv
`timescale 1ns/1ps
module test_raw_guard;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1, wr_done = 0;
  logic [1:0] in_op = 0;
  logic [15:0] in_addr = 0;
  logic in_ready, out_valid;
  logic [1:0] out_op;
  logic [15:0] out_addr;
  logic [6:0] occupancy;
  int checks = 0, fails = 0;
  logic [17:0] expq [$];

  localparam logic [1:0] GET = 2'b00, INS = 2'b01, DEL = 2'b10, RSV = 2'b11;

  always #10 clk = ~clk;

  raw_guard i_raw_guard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_addr(out_addr), .wr_done(wr_done), .occupancy(occupancy));

  // monitor: R11 forwarded requests match driver's expectations in order
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected output op=%0d addr=%0d expected none", out_op, out_addr);
      end else begin
        logic [17:0] e;
        e = expq.pop_front();
        if ({out_op, out_addr} !== e) begin
          fails++;
          $display("FAIL R11 output %h expected %h", {out_op, out_addr}, e);
        end
      end
    end
  end

  task automatic cyc(input bit v, input logic [1:0] op, input logic [15:0] a,
                     input bit done, input bit exp_rdy, input string tag);
    @(posedge clk); #2;
    in_valid = v; in_op = op; in_addr = a; wr_done = done;
    if (v && exp_rdy) expq.push_back({op, a});
    @(negedge clk);
    if (v) begin
      checks++;
      if (in_ready !== exp_rdy) begin
        fails++;
        $display("FAIL %s in_ready=%0b expected %0b", tag, in_ready, exp_rdy);
      end
    end
  endtask

  task automatic chk_cnt(input int exp, input string tag);
    cyc(0, GET, 0, 0, 0, "");
    checks++;
    if (occupancy !== 7'(exp)) begin
      fails++;
      $display("FAIL %s occupancy=%0d expected %0d", tag, occupancy, exp);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk_cnt(0, "R10 reset occupancy");
    cyc(1, INS, 7, 0, 1, "R10 no stall after reset");
    cyc(0, GET, 0, 1, 0, "");
    chk_cnt(0, "R10 cleanup");

    cyc(1, GET, 5, 0, 1, "R2 get passes");
    cyc(1, RSV, 6, 0, 1, "R2 code 11 passes");
    chk_cnt(0, "R2 reads not recorded");

    cyc(1, INS, 10, 0, 1, "R1 insert accepted");
    chk_cnt(1, "R1 insert recorded");
    cyc(1, GET, 10, 0, 0, "R3 get to pending bucket");
    cyc(1, DEL, 10, 0, 0, "R3 delete to pending bucket");
    cyc(1, GET, 11, 0, 1, "R11 other bucket passes");
    cyc(1, DEL, 20, 0, 1, "R1 delete accepted");
    chk_cnt(2, "R1 delete recorded");

    cyc(1, GET, 10, 1, 0, "R5 stalled in release cycle");
    cyc(1, GET, 10, 0, 1, "R5 accepted next cycle");
    cyc(1, GET, 20, 0, 0, "R7 younger entry still stalls");
    chk_cnt(1, "R7 one released");

    cyc(1, INS, 30, 1, 1, "R4 push with release");
    chk_cnt(1, "R4 occupancy unchanged");
    cyc(1, GET, 20, 0, 1, "R4 oldest released");
    cyc(1, GET, 30, 0, 0, "R4 new entry recorded");
    cyc(0, GET, 0, 1, 0, "");
    chk_cnt(0, "R4 drained");

    cyc(0, GET, 0, 1, 0, "");
    chk_cnt(0, "R8 empty release ignored");
    cyc(1, INS, 40, 0, 1, "R8 insert after empty release");
    chk_cnt(1, "R8 count after insert");
    cyc(1, GET, 40, 0, 0, "R8 entry live");
    cyc(0, GET, 0, 1, 0, "");
    chk_cnt(0, "R8 drained");

    out_ready = 0;
    cyc(1, INS, 50, 0, 0, "R9 backpressure holds input");
    chk_cnt(0, "R9 nothing recorded");
    out_ready = 1;
    cyc(1, GET, 50, 0, 1, "R9 bucket not recorded");

    for (int i = 0; i < 64; i++) cyc(1, INS, 16'(100 + i), 0, 1, "R6 fill");
    chk_cnt(64, "R6 full occupancy");
    cyc(1, INS, 500, 0, 0, "R6 insert stalled when full");
    cyc(1, DEL, 501, 0, 0, "R6 delete stalled when full");
    cyc(1, GET, 500, 0, 1, "R6 get passes when full");
    cyc(1, GET, 100, 0, 0, "R3 oldest still recorded");
    cyc(1, INS, 500, 1, 0, "R6 full stalls even with release");
    cyc(1, GET, 100, 0, 1, "R7 oldest released first");
    cyc(1, GET, 101, 0, 0, "R7 second still recorded");
    cyc(1, INS, 500, 0, 1, "R6 insert after release");
    chk_cnt(64, "R6 full again");
    for (int i = 0; i < 64; i++) cyc(0, GET, 0, 1, 0, "");
    chk_cnt(0, "R7 drained");
    cyc(1, INS, 163, 0, 1, "R7 last entry released");

    repeat (3) @(posedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R11 %0d outputs missing expected 0", expq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule